// File: doc/BRIEF.md
# Priority-Ordered Circular Queue Engine

This engine moves one process control record out of one queue and into another. Every queue is a singly linked circular list held in a word-addressed memory. A queue handle is a memory word that holds a pointer to the tail record, and the tail's link word points back to the head. A 15-bit pointer of zero means NIL. Each record takes five consecutive words. Word 0 is the link, word 1 is the cleanup link, word 2 is the timeout, word 3 holds the flags, and word 4 holds the saved frame. Priority is the 3-bit field in bits [2:0] of the flags word, and a larger value means higher priority.

A command gives the process pointer, the destination handle address and a source handle address. Instead of a source handle, the command may carry a flag saying the source queue is unknown. The engine first unlinks the record. It finds the predecessor by walking the ring. It then clears the timeout word and inserts the record into the destination queue in stable priority order. The engine reaches memory through a simple request port with one access per cycle. Writes complete on issue. Reads complete when a read-valid response returns. While it works the engine holds `busy`. At the end it pulses `done` and raises a requeue-performed flag, which a scheduler can sample to decide whether to switch processes.

Top module: `prio_ring_requeue`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `requeued` and `mem_req` are all low.
- R2: A command is accepted when `cmd_valid` is high while `busy` is low. `busy` then stays high until the operation ends, and it falls in the same cycle that `done` rises for exactly one cycle. Commands presented while `busy` is high have no effect.
- R3: The engine issues at most one memory access per cycle. After a read it waits for `mem_rvalid`, and it never accesses address 0.
- R4: Record layout is link at offset 0, cleanup at offset 1, timeout at offset 2, and flags at offset 3 with the priority in bits [2:0]. The frame word at offset 4 and the flags word are never written.
- R5: A record whose link points to itself is the sole member of its queue and has a NIL predecessor. If the source is known, its handle becomes 0.
- R6: Otherwise the engine walks links until it reaches the record whose link equals the process. The walk starts at the source tail when the source is known, and at the process's own successor when it is unknown. The predecessor's link is then overwritten with the removed record's old link.
- R7: When the source is unknown, the record's cleanup word receives its old link and no source handle is written.
- R8: When the source is known and its handle pointed to the removed record, the handle is set to the predecessor. Otherwise the handle is left unchanged.
- R9: The record's timeout word is written to zero on every requeue.
- R10: If the destination handle is 0, the record's link is set to the record itself and the handle is set to the record.
- R11: If the new priority is less than or equal to the destination tail's priority, the record is linked after the tail, points to the old head, and becomes the new tail in the handle. Equal priorities therefore keep arrival order.
- R12: If the new priority is higher than the tail's, the record is inserted just before the first record, counted from the head, whose priority is lower than its own. The destination handle is left unchanged.
- R13: `requeued` goes high together with `done` and stays high until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_src_unknown | input | 1 | Source queue not known; `cmd_src_handle` is ignored |
| cmd_src_handle | input | 15 | Address of the source queue handle |
| cmd_dst_handle | input | 15 | Address of the destination queue handle |
| cmd_proc | input | 15 | Pointer to the record being moved |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| requeued | output | 1 | Requeue-performed flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 15 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |

## Verification
The embedded assertions take the memory image to be well formed. The process must be a member of some ring. When the source is known, it must be the ring its handle names. Every record must sit at a nonzero address that leaves room for five words. Without these conditions the predecessor walk would never end, and a NIL-address access would be legitimate. The bench builds every image from its own list model, so records are always ring members at spaced nonzero addresses. It never pairs an unknown source with the same destination queue, because in that case the untouched source handle could be stale. The bench also returns read data after a rotating latency of one to three cycles, so every read depends on the read-valid wait.

// File: rtl/rq_pkg.sv
package rq_pkg;
    localparam int PTR_W    = 15;
    localparam int DATA_W   = 16;
    localparam int PRIO_W   = 3;
    localparam int OFF_LINK  = 0;
    localparam int OFF_CLEAN = 1;
    localparam int OFF_TMO   = 2;
    localparam int OFF_FLAGS = 3;

    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [PRIO_W-1:0] prio_t;

    typedef struct packed {
        ptr_t src;
        ptr_t dst;
        ptr_t proc;
        logic src_unk;
    } cmd_t;

    typedef enum logic [4:0] {
        S_IDLE, S_RD_PLINK, S_RD_SRC, S_WALK, S_WR_PRED, S_WR_CLEAN,
        S_RD_SRCT, S_WR_SRC, S_WR_TMO, S_RD_DST, S_WR_SELF, S_WR_DST,
        S_RD_PFLG, S_RD_TFLG, S_SRCH_LINK, S_SRCH_FLG, S_WR_PLINK, S_WR_PPLINK
    } st_t;

    function automatic ptr_t ptr_off(ptr_t p, int o);
        return p + ptr_t'(o);
    endfunction

    function automatic ptr_t to_ptr(word_t w);
        return w[PTR_W-1:0];
    endfunction

    function automatic word_t to_word(ptr_t p);
        return {{(DATA_W-PTR_W){1'b0}}, p};
    endfunction

    function automatic logic is_read(st_t s);
        return (s == S_RD_PLINK) || (s == S_RD_SRC) || (s == S_WALK) ||
               (s == S_RD_SRCT) || (s == S_RD_DST) || (s == S_RD_PFLG) ||
               (s == S_RD_TFLG) || (s == S_SRCH_LINK) || (s == S_SRCH_FLG);
    endfunction
endpackage

// File: rtl/rq_prio_cmp.sv
module rq_prio_cmp
    import rq_pkg::*;
#(
    parameter int PW = PRIO_W
) (
    input  logic [PW-1:0] new_prio,
    input  word_t         other_flags,
    output logic          new_le_other
);
    logic [PW-1:0] other_prio;
    assign other_prio   = other_flags[PW-1:0];
    assign new_le_other = (new_prio <= other_prio);
endmodule

// File: rtl/rq_status.sv
module rq_status (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic finish,
    output logic busy,
    output logic done,
    output logic requeued
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            requeued <= 1'b0;
        end else begin
            done <= finish;
            if (start) begin
                busy     <= 1'b1;
                requeued <= 1'b0;
            end else if (finish) begin
                busy     <= 1'b0;
                requeued <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/prio_ring_requeue.sv
module prio_ring_requeue
    import rq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_src_unknown,
    input  logic [PTR_W-1:0]  cmd_src_handle,
    input  logic [PTR_W-1:0]  cmd_dst_handle,
    input  logic [PTR_W-1:0]  cmd_proc,
    output logic              busy,
    output logic              done,
    output logic              requeued,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    st_t   st;
    cmd_t  c;
    ptr_t  plink, cur, pred, tail, pp, tp, rd_ptr;
    prio_t npri;
    logic  app, pending, rx, step, start, finish, le_rd;

    assign rd_ptr  = to_ptr(mem_rdata);
    assign mem_req = (st != S_IDLE) && !pending;
    assign mem_we  = !is_read(st);
    assign rx      = pending && mem_rvalid;
    assign step    = rx || (mem_req && mem_we);
    assign start   = (st == S_IDLE) && cmd_valid;
    assign finish  = mem_req && mem_we &&
                     ((st == S_WR_DST && !app) || st == S_WR_PPLINK);

    rq_prio_cmp u_cmp (
        .new_prio    (npri),
        .other_flags (mem_rdata),
        .new_le_other(le_rd)
    );

    rq_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .finish  (finish),
        .busy    (busy),
        .done    (done),
        .requeued(requeued)
    );

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            S_RD_PLINK:  mem_addr = c.proc;
            S_RD_SRC,
            S_RD_SRCT:   mem_addr = c.src;
            S_WALK:      mem_addr = cur;
            S_WR_PRED:   begin mem_addr = pred; mem_wdata = to_word(plink); end
            S_WR_CLEAN:  begin mem_addr = ptr_off(c.proc, OFF_CLEAN); mem_wdata = to_word(plink); end
            S_WR_SRC:    begin mem_addr = c.src; mem_wdata = to_word(pred); end
            S_WR_TMO:    mem_addr = ptr_off(c.proc, OFF_TMO);
            S_RD_DST:    mem_addr = c.dst;
            S_WR_SELF:   begin mem_addr = ptr_off(c.proc, OFF_LINK); mem_wdata = to_word(c.proc); end
            S_WR_DST:    begin mem_addr = c.dst; mem_wdata = to_word(c.proc); end
            S_RD_PFLG:   mem_addr = ptr_off(c.proc, OFF_FLAGS);
            S_RD_TFLG:   mem_addr = ptr_off(tail, OFF_FLAGS);
            S_SRCH_LINK: mem_addr = ptr_off(pp, OFF_LINK);
            S_SRCH_FLG:  mem_addr = ptr_off(tp, OFF_FLAGS);
            S_WR_PLINK:  begin mem_addr = ptr_off(c.proc, OFF_LINK); mem_wdata = to_word(tp); end
            S_WR_PPLINK: begin mem_addr = ptr_off(pp, OFF_LINK); mem_wdata = to_word(c.proc); end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            c       <= '0;
            pending <= 1'b0;
            app     <= 1'b0;
            plink   <= '0;
            cur     <= '0;
            pred    <= '0;
            tail    <= '0;
            pp      <= '0;
            tp      <= '0;
            npri    <= '0;
        end else begin
            if (mem_req && !mem_we) pending <= 1'b1;
            else if (rx)            pending <= 1'b0;

            if (start) begin
                c   <= '{src: cmd_src_handle, dst: cmd_dst_handle,
                         proc: cmd_proc, src_unk: cmd_src_unknown};
                app <= 1'b0;
                st  <= S_RD_PLINK;
            end else if (step) begin
                case (st)
                    S_RD_PLINK: begin
                        plink <= rd_ptr;
                        if (rd_ptr == c.proc) begin
                            pred <= '0;
                            st   <= c.src_unk ? S_WR_CLEAN : S_RD_SRCT;
                        end else if (c.src_unk) begin
                            cur <= rd_ptr;
                            st  <= S_WALK;
                        end else begin
                            st <= S_RD_SRC;
                        end
                    end
                    S_RD_SRC: begin cur <= rd_ptr; st <= S_WALK; end
                    S_WALK: begin
                        if (rd_ptr == c.proc) begin
                            pred <= cur;
                            st   <= S_WR_PRED;
                        end else begin
                            cur <= rd_ptr;
                        end
                    end
                    S_WR_PRED:  st <= c.src_unk ? S_WR_CLEAN : S_RD_SRCT;
                    S_WR_CLEAN: st <= S_WR_TMO;
                    S_RD_SRCT:  st <= (rd_ptr == c.proc) ? S_WR_SRC : S_WR_TMO;
                    S_WR_SRC:   st <= S_WR_TMO;
                    S_WR_TMO:   st <= S_RD_DST;
                    S_RD_DST: begin
                        tail <= rd_ptr;
                        st   <= (rd_ptr == '0) ? S_WR_SELF : S_RD_PFLG;
                    end
                    S_WR_SELF:  st <= S_WR_DST;
                    S_WR_DST:   st <= app ? S_WR_PLINK : S_IDLE;
                    S_RD_PFLG: begin
                        npri <= mem_rdata[PRIO_W-1:0];
                        st   <= S_RD_TFLG;
                    end
                    S_RD_TFLG: begin
                        app <= le_rd;
                        pp  <= tail;
                        st  <= S_SRCH_LINK;
                    end
                    S_SRCH_LINK: begin
                        tp <= rd_ptr;
                        st <= app ? S_WR_DST : S_SRCH_FLG;
                    end
                    S_SRCH_FLG: begin
                        if (le_rd) begin
                            pp <= tp;
                            st <= S_SRCH_LINK;
                        end else begin
                            st <= S_WR_PLINK;
                        end
                    end
                    S_WR_PLINK:  st <= S_WR_PPLINK;
                    S_WR_PPLINK: st <= S_IDLE;
                    default:     st <= S_IDLE;
                endcase
            end
        end
    end

    AST_NO_NIL_ACCESS: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr != '0)); // R3
    AST_TMO_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && busy && mem_addr == ptr_off(c.proc, OFF_TMO)) |-> (mem_wdata == '0)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R2
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R2
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_valid) |=> $stable(c.proc)); // R2
    AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> requeued); // R13
    AST_NO_FRAME_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_addr != ptr_off(c.proc, 4))); // R4
endmodule

// File: tb/sim_prio_ring_requeue.sv
module sim_prio_ring_requeue;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0, cmd_src_unknown = 1'b0;
    logic [14:0] cmd_src_handle = '0, cmd_dst_handle = '0, cmd_proc = '0;
    logic        busy, done, requeued, mem_req, mem_we;
    logic [14:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;

    int n_tests = 0, n_fail = 0;
    logic [15:0] mem [0:255];
    int rd_cnt = 0, lat = 1;
    logic [7:0] rd_a = '0;

    localparam int NQ = 5;
    int ql [NQ][16];
    int qn [NQ];
    int pr [16];

    always #10 clk = ~clk;

    prio_ring_requeue u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_src_unknown(cmd_src_unknown),
        .cmd_src_handle(cmd_src_handle), .cmd_dst_handle(cmd_dst_handle), .cmd_proc(cmd_proc),
        .busy(busy), .done(done), .requeued(requeued), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (rd_cnt > 0) begin
            rd_cnt <= rd_cnt - 1;
            if (rd_cnt == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[rd_a];
            end
        end
        if (mem_req) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else begin
                rd_a   <= mem_addr[7:0];
                rd_cnt <= lat;
                lat    <= (lat == 3) ? 1 : lat + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock monitor: address legality and done/busy relation
    always @(negedge clk) begin
        if (!rst && mem_req && (mem_addr == 15'd0 || mem_addr > 15'd255)) begin
            n_tests++; n_fail++;
            $display("FAIL R3 actual=%0h expected=nonzero in-range address", mem_addr);
        end
        if (!rst && done && busy) begin
            n_tests++; n_fail++;
            $display("FAIL R2 actual=busy 1 expected=busy 0 with done");
        end
    end

    function automatic int ra(int i); return 64 + 8 * i; endfunction
    function automatic int ha(int k); return 16 + k; endfunction

    task automatic build_image();
        for (int a = 0; a < 256; a++) mem[a] = '0;
        for (int i = 0; i < 16; i++) begin
            mem[ra(i)+1] = 16'h1100 + 16'(i);
            mem[ra(i)+2] = 16'h0200 + 16'(i);
            mem[ra(i)+3] = 16'h2000 + 16'(pr[i]);
            mem[ra(i)+4] = 16'h7700 + 16'(i);
        end
        for (int k = 0; k < NQ; k++) begin
            if (qn[k] != 0) mem[ha(k)] = 16'(ra(ql[k][qn[k]-1]));
            for (int j = 0; j < qn[k]; j++)
                mem[ra(ql[k][j])] = 16'(ra(ql[k][(j+1) % qn[k]]));
        end
    endtask

    // src < 0 : unknown source
    task automatic run_op(input int src, input int dst, input int p, input string tags);
        logic [15:0] ex [0:256];
        int qs = 0, pos = 0, n, pa, oldl, pred, i, tl, bad, cyc;
        build_image();
        for (int a = 0; a < 256; a++) ex[a] = mem[a];
        for (int k = 0; k < NQ; k++)
            for (int j = 0; j < qn[k]; j++)
                if (ql[k][j] == p) begin qs = k; pos = j; end
        n = qn[qs]; pa = ra(p);
        oldl = ra(ql[qs][(pos+1) % n]);
        pred = (n == 1) ? 0 : ra(ql[qs][(pos-1+n) % n]);
        if (n != 1) ex[pred] = 16'(oldl);
        if (src < 0) ex[pa+1] = 16'(oldl);
        else if (int'(ex[ha(src)]) == pa) ex[ha(src)] = 16'(pred);
        ex[pa+2] = '0;
        for (int j = pos; j < n-1; j++) ql[qs][j] = ql[qs][j+1];
        qn[qs]--;
        if (qn[dst] == 0) begin
            ex[pa] = 16'(pa); ex[ha(dst)] = 16'(pa);
            ql[dst][0] = p; qn[dst] = 1;
        end else begin
            tl = ql[dst][qn[dst]-1];
            if (pr[p] <= pr[tl]) begin
                ex[pa] = 16'(ra(ql[dst][0])); ex[ra(tl)] = 16'(pa); ex[ha(dst)] = 16'(pa);
                ql[dst][qn[dst]] = p; qn[dst]++;
            end else begin
                i = 0;
                while (pr[ql[dst][i]] >= pr[p]) i++;
                ex[(i == 0) ? ra(tl) : ra(ql[dst][i-1])] = 16'(pa);
                ex[pa] = 16'(ra(ql[dst][i]));
                for (int j = qn[dst]; j > i; j--) ql[dst][j] = ql[dst][j-1];
                ql[dst][i] = p; qn[dst]++;
            end
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_src_unknown = (src < 0);
        cmd_src_handle = (src < 0) ? 15'h0055 : 15'(ha(src));
        cmd_dst_handle = 15'(ha(dst)); cmd_proc = 15'(pa);
        @(negedge clk);
        check(busy == 1'b1, {"R2 busy after accept ", tags}, busy, 1);
        check(requeued == 1'b0, {"R13 flag cleared on accept ", tags}, requeued, 0);
        // stray command while busy must not be taken (R2)
        cmd_proc = 15'(ra(15)); cmd_dst_handle = 15'(ha(1)); cmd_src_unknown = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
        check(done == 1'b1, {"R2 done seen ", tags}, done, 1);
        check(busy == 1'b0 && requeued == 1'b1, {"R13 flag with done ", tags}, requeued, 1);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, {"R2 single done pulse ", tags}, done, 0);
        check(mem[pa+2] == 16'h0, {"R9 timeout zeroed ", tags}, mem[pa+2], 0);
        check(mem[pa+4] == 16'h7700 + 16'(p) && mem[pa+3] == 16'h2000 + 16'(pr[p]),
              {"R4 frame and flags kept ", tags}, mem[pa+4], 16'h7700 + p);
        bad = -1;
        for (int a = 0; a < 256; a++) if (mem[a] != ex[a] && bad < 0) bad = a;
        check(bad < 0, {"image ", tags}, (bad < 0) ? 0 : mem[bad], (bad < 0) ? 0 : ex[bad]);
        if (bad >= 0) $display("  first mismatch at address %0d", bad);
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) pr[i] = 0;
        pr[0] = 5; pr[1] = 3; pr[2] = 3; pr[3] = 1;
        pr[4] = 6; pr[5] = 2; pr[6] = 4; pr[7] = 7;
        for (int k = 0; k < NQ; k++) qn[k] = 0;
        ql[0][0] = 0; ql[0][1] = 1; ql[0][2] = 2; ql[0][3] = 3; qn[0] = 4;
        ql[2][0] = 4; ql[2][1] = 5; qn[2] = 2;
        ql[3][0] = 6; qn[3] = 1;
        ql[4][0] = 7; qn[4] = 1;
        build_image();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !requeued && !mem_req, "R1 reset state", {busy, done, requeued, mem_req}, 0);
        run_op(0, 1, 1, "R6 R10 middle out, empty destination");
        run_op(0, 2, 3, "R8 R11 tail out, appended");
        run_op(3, 2, 6, "R5 R12 sole member, mid insert");
        run_op(-1, 1, 2, "R7 R11 unknown source, equal priority");
        run_op(-1, 0, 7, "R5 R7 R12 unknown sole, head insert");
        run_op(2, 2, 5, "R6 R12 same queue reorder");
        run_op(1, 0, 1, "R6 R8 R11 head out, append");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule